// File: doc/BRIEF.md
# Selectable Address Relocation and Protection Unit

This unit sits on the path from the processor's address port to physical memory. Each access is handled under one of three protection schemes, picked by a select input. In the fence scheme, a user access below a fence address is refused. In the bounds scheme, a user access outside an inclusive window is refused, and an access inside the window passes at its own address. In the relocating scheme, the user address is a virtual offset from zero: it is checked against a limit and then added to a region base. In kernel mode no check and no relocation is applied under any scheme.

Requests enter on a valid/ready handshake and granted accesses leave on a valid/ready handshake, with one register stage between them. A refused access never reaches the memory side. It raises a fault for one cycle and reports the offending address. The fence, bounds, base and limit registers are loaded through a configuration port, which only kernel mode may use. The operating system reloads them on each context switch.

Back-pressure rules: `req_ready` is high whenever the output stage is empty or is being emptied in the same cycle (`mem_ready` high). While `mem_valid` is high and `mem_ready` is low, the output transfer is held unchanged and no request is accepted. A request that faults is still accepted, but it produces no output transfer.

Top module: `reloc_guard`

## Requirements
- R1: After reset, `mem_valid`, `fault`, `fault_cause` and `mem_addr` are zero and `req_ready` is high. The register reset values are fence 0, lower bound 0, upper bound all ones, base 0 and limit all ones.
- R2: An access accepted with `kernel_mode` high is always granted, with `mem_addr` equal to `req_addr`, whatever the value of `scheme`.
- R3: With `scheme` = 0 (fence), a user access with address below the fence register faults. An access at or above the fence is granted with the address unchanged.
- R4: With `scheme` = 1 (bounds), a user access is granted with the address unchanged when lower <= address <= upper, and faults otherwise.
- R5: With `scheme` = 2 (base plus limit), a user access with address below the limit is granted with `mem_addr` = base + address modulo 2^AW. An access at or above the limit faults and gives no memory transfer.
- R6: With `scheme` = 3, every user access faults.
- R7: A `cfg_load` in kernel mode writes `cfg_data` into the register chosen by `cfg_sel`: 0 fence, 1 lower, 2 upper, 3 base, 4 limit. The new value applies to accesses accepted from the next cycle on.
- R8: A `cfg_load` in user mode leaves every register unchanged. In the next cycle it raises `fault` with `fault_cause` = 2 and `fault_addr` = `cfg_data`.
- R9: A refused access raises `fault` for exactly the cycle after its acceptance, with `fault_cause` = 1 and `fault_addr` = `req_addr`.
- R10: `mem_addr` and `mem_write` change only when an access is granted. After a refused access they hold their previous values.
- R11: `req_ready` = !`mem_valid` || `mem_ready`. While the output is stalled, `mem_valid`, `mem_addr` and `mem_write` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor access request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | AW | Processor address |
| req_write | input | 1 | 1 = write, 0 = read |
| kernel_mode | input | 1 | 1 = kernel, bypasses checks |
| scheme | input | 2 | 0 fence, 1 bounds, 2 base plus limit, 3 deny user |
| cfg_load | input | 1 | Register load strobe |
| cfg_sel | input | 3 | Register select for load |
| cfg_data | input | AW | Register load value |
| mem_valid | output | 1 | Granted access toward memory |
| mem_ready | input | 1 | Memory accepts the access |
| mem_addr | output | AW | Physical address |
| mem_write | output | 1 | Write flag of granted access |
| fault | output | 1 | Protection fault pulse |
| fault_cause | output | 2 | 1 access violation, 2 privileged register load |
| fault_addr | output | AW | Offending address or rejected load value |

## Verification
The assertions run on every cycle. They check the output handshake rules (stall stability and the ready equation), that a fault follows only an accepted request or a load attempt, that kernel accesses pass through unrelocated and never fault, and that the physical address holds while nothing is granted. Only the bench scenarios can show the boundary values of each scheme: the fence edge, both inclusive bounds, limit minus one against the limit, and base addition that wraps. They also show that a refused user load really leaves the old register value in force. This is observed through a later access.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic [1:0] {
    SCH_FENCE  = 2'd0,
    SCH_BOUNDS = 2'd1,
    SCH_BASE   = 2'd2,
    SCH_DENY   = 2'd3
  } scheme_t;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ACCESS = 2'd1,
    CAUSE_PRIV   = 2'd2
  } cause_t;

  localparam logic [2:0] SEL_FENCE = 3'd0;
  localparam logic [2:0] SEL_LOWER = 3'd1;
  localparam logic [2:0] SEL_UPPER = 3'd2;
  localparam logic [2:0] SEL_BASE  = 3'd3;
  localparam logic [2:0] SEL_LIMIT = 3'd4;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          kernel_mode,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] fence_q,
  output logic [AW-1:0] lower_q,
  output logic [AW-1:0] upper_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] limit_q
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  logic wr_en;
  assign wr_en = cfg_load && kernel_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fence_q <= '0;
      lower_q <= '0;
      upper_q <= ALL_ONES;
      base_q  <= '0;
      limit_q <= ALL_ONES;
    end else if (wr_en) begin
      case (cfg_sel)
        SEL_FENCE: fence_q <= cfg_data;
        SEL_LOWER: lower_q <= cfg_data;
        SEL_UPPER: upper_q <= cfg_data;
        SEL_BASE:  base_q  <= cfg_data;
        SEL_LIMIT: limit_q <= cfg_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/reloc_check.sv
module reloc_check
  import reloc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          kernel_mode,
  input  logic [1:0]    scheme,
  input  logic [AW-1:0] fence_q,
  input  logic [AW-1:0] lower_q,
  input  logic [AW-1:0] upper_q,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] limit_q,
  output logic          allow,
  output logic [AW-1:0] phys
);
  logic          fence_ok;
  logic          bounds_ok;
  logic          limit_ok;
  logic [AW-1:0] relocated;

  assign fence_ok  = addr >= fence_q;
  assign bounds_ok = (addr >= lower_q) && (addr <= upper_q);
  assign limit_ok  = addr < limit_q;
  assign relocated = base_q + addr;

  always_comb begin
    allow = 1'b0;
    phys  = addr;
    if (kernel_mode) begin
      allow = 1'b1;
    end else begin
      case (scheme_t'(scheme))
        SCH_FENCE:  allow = fence_ok;
        SCH_BOUNDS: allow = bounds_ok;
        SCH_BASE: begin
          allow = limit_ok;
          phys  = relocated;
        end
        default:    allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          kernel_mode,
  input  logic [1:0]    scheme,
  input  logic          cfg_load,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic          fault,
  output logic [1:0]    fault_cause,
  output logic [AW-1:0] fault_addr
);
  logic [AW-1:0] fence_q, lower_q, upper_q, base_q, limit_q;
  logic          allow;
  logic [AW-1:0] phys;
  logic          accept;

  reloc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .kernel_mode(kernel_mode),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .fence_q(fence_q), .lower_q(lower_q), .upper_q(upper_q),
    .base_q(base_q), .limit_q(limit_q)
  );

  reloc_check #(.AW(AW)) u_check (
    .addr(req_addr), .kernel_mode(kernel_mode), .scheme(scheme),
    .fence_q(fence_q), .lower_q(lower_q), .upper_q(upper_q),
    .base_q(base_q), .limit_q(limit_q), .allow(allow), .phys(phys)
  );

  assign req_ready = !mem_valid || mem_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_write   <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= CAUSE_NONE;
      fault_addr  <= '0;
    end else begin
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= CAUSE_NONE;
      if (cfg_load && !kernel_mode) begin
        fault       <= 1'b1;
        fault_cause <= CAUSE_PRIV;
        fault_addr  <= cfg_data;
      end
      if (accept) begin
        if (allow) begin
          mem_valid <= 1'b1;
          mem_addr  <= phys;
          mem_write <= req_write;
        end else begin
          fault       <= 1'b1;
          fault_cause <= CAUSE_ACCESS;
          fault_addr  <= req_addr;
        end
      end
    end
  end
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          kernel_mode,
  input logic          cfg_load,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_write,
  input logic          fault
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_ready_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !req_ready);

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  assert_fault_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(acc || cfg_load));

  assert_kernel_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && kernel_mode |=> mem_valid && mem_addr == $past(req_addr));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> $stable(mem_addr));
endmodule

bind reloc_guard reloc_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .kernel_mode(kernel_mode), .cfg_load(cfg_load),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_write(mem_write), .fault(fault)
);

// File: tb/test_reloc_guard.sv
module test_reloc_guard;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write, kernel_mode;
  logic [AW-1:0] req_addr;
  logic [1:0]    scheme;
  logic          cfg_load;
  logic [2:0]    cfg_sel;
  logic [AW-1:0] cfg_data;
  logic          mem_valid, mem_ready, mem_write, fault;
  logic [AW-1:0] mem_addr, fault_addr;
  logic [1:0]    fault_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  reloc_guard #(.AW(AW)) i_reloc_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .kernel_mode(kernel_mode),
    .scheme(scheme), .cfg_load(cfg_load), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_write(mem_write), .fault(fault), .fault_cause(fault_cause),
    .fault_addr(fault_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit kmode, input logic [2:0] sel, input logic [AW-1:0] val);
    @(negedge clk);
    cfg_load = 1'b1; cfg_sel = sel; cfg_data = val; kernel_mode = kmode;
    @(negedge clk);
    cfg_load = 1'b0; kernel_mode = 1'b1;
  endtask

  // One request; the outputs are sampled in the cycle after acceptance.
  task automatic access(input logic [AW-1:0] a, input bit w, input bit kmode, input logic [1:0] sch);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; kernel_mode = kmode; scheme = sch;
    @(negedge clk);
    req_valid = 1'b0; kernel_mode = 1'b1;
  endtask

  task automatic expect_grant(input string tag, input logic [AW-1:0] a, input logic [AW-1:0] p,
                              input bit kmode, input logic [1:0] sch);
    access(a, 1'b1, kmode, sch);
    check(mem_valid && !fault, {tag, " grant"}, {fault, mem_valid}, 32'h1);
    check(mem_addr == p, {tag, " phys"}, mem_addr, p);
    check(mem_write == 1'b1, {tag, " write flag"}, mem_write, 1);
  endtask

  task automatic expect_fault(input string tag, input logic [AW-1:0] a, input logic [1:0] sch);
    logic [AW-1:0] held;
    held = mem_addr;
    access(a, 1'b0, 1'b0, sch);
    check(fault && !mem_valid, {tag, " fault"}, {fault, mem_valid}, 32'h2);
    check(fault_cause == 2'd1, {tag, " R9 cause"}, fault_cause, 1);
    check(fault_addr == a, {tag, " R9 fault_addr"}, fault_addr, a);
    check(mem_addr == held, {tag, " R10 hold"}, mem_addr, held);
    @(negedge clk);
    check(!fault, {tag, " R9 single pulse"}, fault, 0);
  endtask

  task automatic t_reset;
    check(!mem_valid && !fault && fault_cause == 0 && mem_addr == 0, "R1 outputs",
          {mem_valid, fault, fault_cause, mem_addr}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    expect_grant("R1 default fence 0", 16'h0000, 16'h0000, 1'b0, 2'd0);
    expect_grant("R1 default limit", 16'hFFFE, 16'hFFFE, 1'b0, 2'd2);
  endtask

  task automatic t_load;
    cfg_write(1'b1, 3'd0, 16'h1000);
    cfg_write(1'b1, 3'd1, 16'h2000);
    cfg_write(1'b1, 3'd2, 16'h2FFF);
    cfg_write(1'b1, 3'd3, 16'h8000);
    cfg_write(1'b1, 3'd4, 16'h0400);
  endtask

  task automatic t_fence;
    expect_grant("R3 at fence", 16'h1000, 16'h1000, 1'b0, 2'd0);
    expect_fault("R3 below fence", 16'h0FFF, 2'd0);
    expect_grant("R3 high", 16'hF00D, 16'hF00D, 1'b0, 2'd0);
  endtask

  task automatic t_bounds;
    expect_fault("R4 below lower", 16'h1FFF, 2'd1);
    expect_grant("R4 at lower", 16'h2000, 16'h2000, 1'b0, 2'd1);
    expect_grant("R4 at upper", 16'h2FFF, 16'h2FFF, 1'b0, 2'd1);
    expect_fault("R4 above upper", 16'h3000, 2'd1);
  endtask

  task automatic t_base;
    expect_grant("R5 zero", 16'h0000, 16'h8000, 1'b0, 2'd2);
    expect_grant("R5 limit-1", 16'h03FF, 16'h83FF, 1'b0, 2'd2);
    expect_fault("R5 at limit", 16'h0400, 2'd2);
    cfg_write(1'b1, 3'd3, 16'hFF00);
    expect_grant("R7 R5 wrap", 16'h0200, 16'h0100, 1'b0, 2'd2);
  endtask

  task automatic t_deny;
    expect_fault("R6 deny", 16'h2100, 2'd3);
  endtask

  task automatic t_kernel;
    expect_grant("R2 kernel base", 16'h5000, 16'h5000, 1'b1, 2'd2);
    expect_grant("R2 kernel fence", 16'h0001, 16'h0001, 1'b1, 2'd0);
    expect_grant("R2 kernel deny", 16'h3000, 16'h3000, 1'b1, 2'd3);
  endtask

  task automatic t_user_cfg;
    @(negedge clk);
    cfg_load = 1'b1; cfg_sel = 3'd0; cfg_data = 16'h4000; kernel_mode = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0; kernel_mode = 1'b1;
    check(fault && fault_cause == 2'd2, "R8 priv fault", {fault, fault_cause}, 32'h6);
    check(fault_addr == 16'h4000, "R8 fault_addr", fault_addr, 16'h4000);
    expect_grant("R8 fence unchanged", 16'h1000, 16'h1000, 1'b0, 2'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    mem_ready = 1'b0;
    expect_grant("R11 first", 16'h1234, 16'h1234, 1'b1, 2'd0);
    check(!req_ready, "R11 ready low", req_ready, 0);
    req_valid = 1'b1; req_addr = 16'h4321; req_write = 1'b0; kernel_mode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(mem_valid && mem_addr == 16'h1234 && mem_write, "R11 stall hold", mem_addr, 16'h1234);
    mem_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_valid && mem_addr == 16'h4321 && !mem_write, "R11 queued accepted", mem_addr, 16'h4321);
    @(negedge clk);
    check(!mem_valid, "R11 drained", mem_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_write = 0; kernel_mode = 1'b1;
    scheme = 2'd0; cfg_load = 0; cfg_sel = '0; cfg_data = '0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load;
    t_fence;
    t_bounds;
    t_base;
    t_deny;
    t_kernel;
    t_user_cfg;
    t_backpressure;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule